// File: doc/BRIEF.md
# Four-Slot TDM Channel Port with Chained Frame Pulse

This block links a line transceiver to a 2.048 Mbit/s time-division-multiplexed backplane stream. The bit clock runs at 4.096 MHz, so each serial bit lasts two clock cycles. An active-low 8 kHz pulse marks each frame of 256 bits. The port uses only the first four 8-bit timeslots of every frame. In order, these are a signalling (D) byte, a control/status (C) byte, and two bearer bytes B1 and B2. It receives these four bytes from the incoming line and sends four bytes of its own on the outgoing line. Outside those timeslots its output enable stays low.

After reset, the first falling edge of the frame pulse synchronises the port. From then on its frame counter runs freely. The port also regenerates a delayed frame pulse. A second port fed with this pulse places its own four timeslots directly after the first port's, so a chain of ports can fill a whole frame.

A mode input picks one of two D-channel rates. At 16 kbit/s the D channel uses only two bits of timeslot 0. At 64 kbit/s the D channel takes over the B1 timeslot in full. Each received C byte writes one of two control registers.

Top module: `tdm_chan_port`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `ser_oe_o` is 0, `ser_o` is 1, `frame_dly_n_o` is 1, `rx_vld_o` is 0 and both control registers are 0.
- R2: A frame starts on the first clock edge at which `frame_n_i` is sampled low after being high. Holding it low for more edges does not restart the frame. Before the first frame start the port never drives the line and never pulses `frame_dly_n_o`.
- R3: Each bit lasts two clocks, and bytes are sent and received MSB first. `ser_o` changes only on the first clock of a bit: bit b appears in cycles 2b and 2b+1 after the start edge. `ser_i` is sampled only on the second clock of a bit.
- R4: Slots 0 to 3 (bits 0 to 31) carry D, C, B1 and B2 in that order, with `ser_oe_o` high. During bits 32 to 255 `ser_oe_o` is low and `ser_o` is 1.
- R5: The transmit bytes and `d64_i` are captured at the frame start edge. Later changes to them have no effect until the next frame.
- R6: With `d64_i` = 0, slot 0 sends `tx_d_i[7:6]` followed by six 1 bits. The received D byte is presented as the two received MSBs followed by six 0 bits.
- R7: With `d64_i` = 1, slot 2 carries the full D byte in both directions and slot 0 sends 8'hFF. Slot 0 produces no receive strobe, and slot 2 is reported with channel code 0 (D).
- R8: After the last bit of each used slot is sampled, `rx_vld_o` is high for exactly one cycle, 16c+16 cycles after the start edge for slot c. At the same time `rx_data_o` holds the byte and `rx_chan_o` holds the channel code (0 = D, 1 = C, 2 = B1, 3 = B2).
- R9: A received C byte with bit 7 = 0 loads bits 6:0 into `ctrl_a_o`. With bit 7 = 1 it loads them into `ctrl_b_o`. The register changes in the same cycle as the C strobe.
- R10: `frame_dly_n_o` is low for exactly the two cycles that are 63 and 64 cycles after the start edge. A downstream port's bit 0 therefore lines up with this port's bit 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4.096 MHz bit clock (two cycles per bit) |
| rst | input | 1 | Synchronous active-high reset |
| frame_n_i | input | 1 | Active-low frame pulse, system or upstream delayed pulse |
| ser_i | input | 1 | Incoming serial stream |
| d64_i | input | 1 | 1 selects the 64 kbit/s D channel in slot 2 |
| tx_d_i | input | 8 | D byte to send |
| tx_c_i | input | 8 | Control/status byte to send |
| tx_b1_i | input | 8 | B1 byte to send |
| tx_b2_i | input | 8 | B2 byte to send |
| ser_o | output | 1 | Outgoing serial data |
| ser_oe_o | output | 1 | Output enable for the outgoing line driver |
| frame_dly_n_o | output | 1 | Delayed active-low frame pulse for the next port |
| rx_data_o | output | 8 | Received byte |
| rx_chan_o | output | 2 | Channel code of the received byte |
| rx_vld_o | output | 1 | One-cycle strobe for `rx_data_o` and `rx_chan_o` |
| ctrl_a_o | output | 7 | Control register written by C bytes with bit 7 = 0 |
| ctrl_b_o | output | 7 | Control register written by C bytes with bit 7 = 1 |

## Verification
The bench drives the inverse of each bit during that bit's first clock. A port that sampled a clock early would then receive every byte inverted. The bench also changes the parallel transmit bytes and the mode input a few cycles into a frame, which catches a design that reads them live instead of capturing them at frame start. One frame pulse is held low for three clocks: a level-sensitive start would shift every slot and move the delayed pulse. Frames alternate between the two D-channel rates and check the delayed pulse's position and width, which catches a remap into the wrong slot, a stray strobe in slot 0, an unmasked D field, or a delayed pulse that is one cycle off.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int CH_BITS  = 8;
  localparam int N_SLOTS  = 4;
  localparam int D16_BITS = 2;
  localparam int SLOT_W   = $clog2(N_SLOTS);
  localparam int POS_W    = $clog2(CH_BITS);

  typedef enum logic [SLOT_W-1:0] {
    CH_D  = 2'd0,
    CH_C  = 2'd1,
    CH_B1 = 2'd2,
    CH_B2 = 2'd3
  } chan_e;
endpackage

// File: rtl/tdm_timing.sv
module tdm_timing
  import tdm_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int CNT_W      = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_n_i,
  output logic             start_o,
  output logic [CNT_W-1:0] cnt_q_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             synced_q_o,
  output logic             synced_nxt_o,
  output logic             fdly_n_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS * 2 - 1);
  localparam logic [CNT_W-1:0] DLY0 = CNT_W'(N_SLOTS * CH_BITS * 2 - 1);
  localparam logic [CNT_W-1:0] DLY1 = CNT_W'(N_SLOTS * CH_BITS * 2);

  logic fr_prev;

  always_comb begin
    start_o      = ~frame_n_i & fr_prev;
    synced_nxt_o = synced_q_o | start_o;
    if (start_o || cnt_q_o == LAST) cnt_nxt_o = '0;
    else                            cnt_nxt_o = cnt_q_o + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fr_prev    <= 1'b1;
      cnt_q_o    <= '0;
      synced_q_o <= 1'b0;
      fdly_n_o   <= 1'b1;
    end else begin
      fr_prev    <= frame_n_i;
      cnt_q_o    <= cnt_nxt_o;
      synced_q_o <= synced_nxt_o;
      fdly_n_o   <= ~(synced_nxt_o && (cnt_nxt_o == DLY0 || cnt_nxt_o == DLY1));
    end
  end
endmodule

// File: rtl/tdm_tx.sv
module tdm_tx
  import tdm_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [CNT_W-1:0]   cnt_nxt_i,
  input  logic               synced_nxt_i,
  input  logic               d64_i,
  input  logic [CH_BITS-1:0] d_i,
  input  logic [CH_BITS-1:0] c_i,
  input  logic [CH_BITS-1:0] b1_i,
  input  logic [CH_BITS-1:0] b2_i,
  output logic               ser_o,
  output logic               ser_oe_o,
  output logic               d64_q_o
);
  localparam int IDX_W = CNT_W - 1;

  logic [CH_BITS-1:0] lat       [N_SLOTS];
  logic [CH_BITS-1:0] raw       [N_SLOTS];
  logic [CH_BITS-1:0] slot_byte [N_SLOTS];
  logic               mode;
  logic [IDX_W-1:0]   bit_idx;
  logic [IDX_W-1:0]   slot_full;
  logic [SLOT_W-1:0]  slot;
  logic [POS_W-1:0]   pos;
  logic               in_win;
  logic               drive;

  always_comb begin
    if (start_i) begin
      raw[0] = d_i;
      raw[1] = c_i;
      raw[2] = b1_i;
      raw[3] = b2_i;
      mode   = d64_i;
    end else begin
      raw  = lat;
      mode = d64_q_o;
    end
    slot_byte[0] = mode ? {CH_BITS{1'b1}}
                        : {raw[0][CH_BITS-1 -: D16_BITS], {(CH_BITS-D16_BITS){1'b1}}};
    slot_byte[1] = raw[1];
    slot_byte[2] = mode ? raw[0] : raw[2];
    slot_byte[3] = raw[3];

    bit_idx   = cnt_nxt_i[CNT_W-1:1];
    slot_full = bit_idx >> POS_W;
    slot      = slot_full[SLOT_W-1:0];
    pos       = ~bit_idx[POS_W-1:0];
    in_win    = slot_full < IDX_W'(N_SLOTS);
    drive     = synced_nxt_i & in_win;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_o    <= 1'b1;
      ser_oe_o <= 1'b0;
      d64_q_o  <= 1'b0;
      for (int k = 0; k < N_SLOTS; k++) lat[k] <= '0;
    end else begin
      if (start_i) begin
        lat[0]  <= d_i;
        lat[1]  <= c_i;
        lat[2]  <= b1_i;
        lat[3]  <= b2_i;
        d64_q_o <= d64_i;
      end
      if (!cnt_nxt_i[0]) begin
        ser_oe_o <= drive;
        ser_o    <= drive ? slot_byte[slot][pos] : 1'b1;
      end
    end
  end
endmodule

// File: rtl/tdm_rx.sv
module tdm_rx
  import tdm_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CNT_W-1:0]   cnt_q_i,
  input  logic               synced_q_i,
  input  logic               d64_q_i,
  input  logic               ser_i,
  output logic [CH_BITS-1:0] rx_data_o,
  output logic [SLOT_W-1:0]  rx_chan_o,
  output logic               rx_vld_o,
  output logic [CH_BITS-2:0] ctrl_a_o,
  output logic [CH_BITS-2:0] ctrl_b_o
);
  localparam int IDX_W = CNT_W - 1;

  logic [CH_BITS-2:0] sh;
  logic [CH_BITS-1:0] byte_w;
  logic [IDX_W-1:0]   bit_idx;
  logic [IDX_W-1:0]   slot_full;
  chan_e              slot_e;
  logic               samp;
  logic               done_byte;

  always_comb begin
    byte_w    = {sh, ser_i};
    bit_idx   = cnt_q_i[CNT_W-1:1];
    slot_full = bit_idx >> POS_W;
    slot_e    = chan_e'(slot_full[SLOT_W-1:0]);
    samp      = synced_q_i & cnt_q_i[0];
    done_byte = samp && (&bit_idx[POS_W-1:0]) && (slot_full < IDX_W'(N_SLOTS));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh        <= '0;
      rx_data_o <= '0;
      rx_chan_o <= '0;
      rx_vld_o  <= 1'b0;
      ctrl_a_o  <= '0;
      ctrl_b_o  <= '0;
    end else begin
      rx_vld_o <= 1'b0;
      if (samp) sh <= byte_w[CH_BITS-2:0];
      if (done_byte) begin
        case (slot_e)
          CH_D: if (!d64_q_i) begin
            rx_vld_o  <= 1'b1;
            rx_chan_o <= CH_D;
            rx_data_o <= {byte_w[CH_BITS-1 -: D16_BITS], {(CH_BITS-D16_BITS){1'b0}}};
          end
          CH_C: begin
            rx_vld_o  <= 1'b1;
            rx_chan_o <= CH_C;
            rx_data_o <= byte_w;
            if (byte_w[CH_BITS-1]) ctrl_b_o <= byte_w[CH_BITS-2:0];
            else                   ctrl_a_o <= byte_w[CH_BITS-2:0];
          end
          CH_B1: begin
            rx_vld_o  <= 1'b1;
            rx_chan_o <= d64_q_i ? CH_D : CH_B1;
            rx_data_o <= byte_w;
          end
          default: begin
            rx_vld_o  <= 1'b1;
            rx_chan_o <= CH_B2;
            rx_data_o <= byte_w;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/tdm_chan_port.sv
module tdm_chan_port
  import tdm_pkg::*;
#(
  parameter int FRAME_BITS = 256
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_n_i,
  input  logic               ser_i,
  input  logic               d64_i,
  input  logic [CH_BITS-1:0] tx_d_i,
  input  logic [CH_BITS-1:0] tx_c_i,
  input  logic [CH_BITS-1:0] tx_b1_i,
  input  logic [CH_BITS-1:0] tx_b2_i,
  output logic               ser_o,
  output logic               ser_oe_o,
  output logic               frame_dly_n_o,
  output logic [CH_BITS-1:0] rx_data_o,
  output logic [SLOT_W-1:0]  rx_chan_o,
  output logic               rx_vld_o,
  output logic [CH_BITS-2:0] ctrl_a_o,
  output logic [CH_BITS-2:0] ctrl_b_o
);
  localparam int CNT_W = $clog2(FRAME_BITS * 2);

  logic             start;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             synced_q;
  logic             synced_nxt;
  logic             d64_q;

  tdm_timing #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_timing (
    .clk(clk), .rst(rst), .frame_n_i(frame_n_i),
    .start_o(start), .cnt_q_o(cnt_q), .cnt_nxt_o(cnt_nxt),
    .synced_q_o(synced_q), .synced_nxt_o(synced_nxt), .fdly_n_o(frame_dly_n_o)
  );

  tdm_tx #(.CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst(rst), .start_i(start), .cnt_nxt_i(cnt_nxt),
    .synced_nxt_i(synced_nxt), .d64_i(d64_i),
    .d_i(tx_d_i), .c_i(tx_c_i), .b1_i(tx_b1_i), .b2_i(tx_b2_i),
    .ser_o(ser_o), .ser_oe_o(ser_oe_o), .d64_q_o(d64_q)
  );

  tdm_rx #(.CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst(rst), .cnt_q_i(cnt_q), .synced_q_i(synced_q),
    .d64_q_i(d64_q), .ser_i(ser_i),
    .rx_data_o(rx_data_o), .rx_chan_o(rx_chan_o), .rx_vld_o(rx_vld_o),
    .ctrl_a_o(ctrl_a_o), .ctrl_b_o(ctrl_b_o)
  );
endmodule

// File: rtl/tdm_chan_port_chk.sv
module tdm_chan_port_chk
  import tdm_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               ser_o,
  input logic               ser_oe_o,
  input logic               frame_dly_n_o,
  input logic               rx_vld_o,
  input logic [SLOT_W-1:0]  rx_chan_o,
  input logic [CH_BITS-2:0] ctrl_a_o,
  input logic [CH_BITS-2:0] ctrl_b_o
);
  localparam int RUN_MAX = 2 * N_SLOTS * CH_BITS;
  localparam int RUN_W   = $clog2(RUN_MAX) + 2;

  logic [RUN_W-1:0] oe_run;

  always_ff @(posedge clk) begin
    if (rst)           oe_run <= '0;
    else if (!ser_oe_o) oe_run <= '0;
    else if (oe_run != {RUN_W{1'b1}}) oe_run <= oe_run + 1'b1;
  end

  AST_RST_QUIET: assert property (@(posedge clk) rst |=> (!ser_oe_o && ser_o && frame_dly_n_o && !rx_vld_o)); // R1
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst) !ser_oe_o |-> ser_o); // R4
  AST_OE_SPAN: assert property (@(posedge clk) disable iff (rst) oe_run <= RUN_W'(RUN_MAX)); // R4
  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ser_oe_o && $past(ser_oe_o) && ser_o != $past(ser_o)) |=> $stable(ser_o)); // R3
  AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (rst) rx_vld_o |=> !rx_vld_o); // R8
  AST_CTRL_A_SRC: assert property (@(posedge clk) disable iff (rst)
    (ctrl_a_o != $past(ctrl_a_o)) |-> (rx_vld_o && rx_chan_o == CH_C)); // R9
  AST_CTRL_B_SRC: assert property (@(posedge clk) disable iff (rst)
    (ctrl_b_o != $past(ctrl_b_o)) |-> (rx_vld_o && rx_chan_o == CH_C)); // R9
  AST_DLY_TWO: assert property (@(posedge clk) disable iff (rst)
    $fell(frame_dly_n_o) |=> !frame_dly_n_o); // R10
  AST_DLY_END: assert property (@(posedge clk) disable iff (rst)
    (!frame_dly_n_o && !$past(frame_dly_n_o)) |=> frame_dly_n_o); // R10
endmodule

bind tdm_chan_port tdm_chan_port_chk u_chk (
  .clk(clk), .rst(rst), .ser_o(ser_o), .ser_oe_o(ser_oe_o),
  .frame_dly_n_o(frame_dly_n_o), .rx_vld_o(rx_vld_o), .rx_chan_o(rx_chan_o),
  .ctrl_a_o(ctrl_a_o), .ctrl_b_o(ctrl_b_o)
);

// File: tb/tdm_chan_port_tb.sv
module tdm_chan_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME_BITS = 256;
  localparam int FCLKS      = FRAME_BITS * 2;
  localparam int NV         = 5;
  // {mode, tx D,C,B1,B2, rx slot0..slot3 as on the wire}
  localparam logic [64:0] VEC [NV] = '{
    {1'b0, 32'hA53C960F, 32'hC3815AF0},
    {1'b0, 32'h5A00FF81, 32'h7F2A00FF},
    {1'b1, 32'h6E123456, 32'h0F85B7E1},
    {1'b1, 32'hFFC0AA55, 32'h00001122},
    {1'b0, 32'h00FF00FF, 32'hFFFFFF00}
  };

  logic       clk = 1'b0;
  logic       rst, frame_n, ser_i, d64;
  logic [7:0] tx_d, tx_c, tx_b1, tx_b2;
  logic       ser_o, ser_oe, fdly_n, rx_vld;
  logic [7:0] rx_data;
  logic [1:0] rx_chan;
  logic [6:0] ctrl_a, ctrl_b;
  logic [6:0] exp_a, exp_b;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_chan_port #(.FRAME_BITS(FRAME_BITS)) u_dut (
    .clk(clk), .rst(rst), .frame_n_i(frame_n), .ser_i(ser_i), .d64_i(d64),
    .tx_d_i(tx_d), .tx_c_i(tx_c), .tx_b1_i(tx_b1), .tx_b2_i(tx_b2),
    .ser_o(ser_o), .ser_oe_o(ser_oe), .frame_dly_n_o(fdly_n),
    .rx_data_o(rx_data), .rx_chan_o(rx_chan), .rx_vld_o(rx_vld),
    .ctrl_a_o(ctrl_a), .ctrl_b_o(ctrl_b)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Called at a negedge; the following posedge is the frame start edge.
  task automatic run_frame(input logic [64:0] v, input int plen);
    logic       m;
    logic [7:0] tb [4];
    logic [7:0] rb [4];
    logic [7:0] txs [4];
    m = v[64];
    tb[0] = v[63:56]; tb[1] = v[55:48]; tb[2] = v[47:40]; tb[3] = v[39:32];
    rb[0] = v[31:24]; rb[1] = v[23:16]; rb[2] = v[15:8];  rb[3] = v[7:0];
    txs[0] = m ? 8'hFF : {tb[0][7:6], 6'h3F};
    txs[1] = tb[1];
    txs[2] = m ? tb[0] : tb[2];
    txs[3] = tb[3];
    d64 = m; tx_d = tb[0]; tx_c = tb[1]; tx_b1 = tb[2]; tx_b2 = tb[3];
    frame_n = 1'b0;
    for (int i = 0; i < FCLKS; i++) begin
      int   b;
      logic bitv, exp_oe, exp_ser, exp_v;
      string tg;
      @(negedge clk);
      b = i >> 1;
      if (i == plen - 1) frame_n = 1'b1;
      if (i == 3) begin // R5: late changes must not reach the line
        tx_d = ~tb[0]; tx_c = ~tb[1]; tx_b1 = ~tb[2]; tx_b2 = ~tb[3]; d64 = ~m;
      end
      // R3: wrong value during the first clock of each bit
      bitv  = (b < 32) ? rb[b >> 3][7 - (b & 7)] : 1'b0;
      ser_i = (i % 2 == 1) ? bitv : ~bitv;
      exp_oe  = (b < 32);
      exp_ser = exp_oe ? txs[b >> 3][7 - (b & 7)] : 1'b1;
      if (b < 8 || (m && b >= 16 && b < 24)) tg = m ? "R7" : "R6";
      else if (b < 32 && i >= 6)             tg = "R5";
      else                                   tg = "R3";
      chk(ser_oe == exp_oe, "R4", "output enable", 32'(ser_oe), 32'(exp_oe));
      chk(ser_o == exp_ser, tg, "serial out bit", 32'(ser_o), 32'(exp_ser));
      chk(fdly_n == !(i == 63 || i == 64), "R10", "delayed pulse",
          32'(fdly_n), 32'(!(i == 63 || i == 64)));
      exp_v = (i == 16 && !m) || i == 32 || i == 48 || i == 64;
      chk(rx_vld == exp_v, "R8", "rx strobe", 32'(rx_vld), 32'(exp_v));
      if (exp_v && i == 16) begin
        chk(rx_chan == 2'd0, "R6", "D chan", 32'(rx_chan), 0);
        chk(rx_data == {rb[0][7:6], 6'h00}, "R6", "D data", 32'(rx_data), 32'({rb[0][7:6], 6'h00}));
      end
      if (i == 32) begin
        chk(rx_chan == 2'd1, "R8", "C chan", 32'(rx_chan), 1);
        chk(rx_data == rb[1], "R3", "C data", 32'(rx_data), 32'(rb[1]));
        if (rb[1][7]) exp_b = rb[1][6:0];
        else          exp_a = rb[1][6:0];
        chk(ctrl_a == exp_a, "R9", "ctrl_a", 32'(ctrl_a), 32'(exp_a));
        chk(ctrl_b == exp_b, "R9", "ctrl_b", 32'(ctrl_b), 32'(exp_b));
      end
      if (i == 48) begin
        chk(rx_chan == (m ? 2'd0 : 2'd2), "R7", "slot2 chan", 32'(rx_chan), m ? 0 : 2);
        chk(rx_data == rb[2], "R7", "slot2 data", 32'(rx_data), 32'(rb[2]));
      end
      if (i == 64) begin
        chk(rx_chan == 2'd3, "R8", "B2 chan", 32'(rx_chan), 3);
        chk(rx_data == rb[3], "R3", "B2 data", 32'(rx_data), 32'(rb[3]));
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; frame_n = 1'b1; ser_i = 1'b0; d64 = 1'b0;
    tx_d = '0; tx_c = '0; tx_b1 = '0; tx_b2 = '0;
    exp_a = '0; exp_b = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!ser_oe, "R1", "oe in reset", 32'(ser_oe), 0);
    chk(ser_o, "R1", "ser in reset", 32'(ser_o), 1);
    chk(fdly_n, "R1", "fdly in reset", 32'(fdly_n), 1);
    chk(!rx_vld, "R1", "vld in reset", 32'(rx_vld), 0);
    chk(ctrl_a == 0 && ctrl_b == 0, "R1", "ctrl in reset", 32'({ctrl_a, ctrl_b}), 0);
    rst = 1'b0;
    // R2: no activity before the first frame pulse
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      chk(!ser_oe && fdly_n && !rx_vld, "R2", "idle before sync",
          32'({ser_oe, fdly_n, rx_vld}), 32'(3'b010));
    end
    // Vector table; last frame holds the pulse low for 3 clocks (R2)
    for (int k = 0; k < NV; k++) run_frame(VEC[k], (k == NV - 1) ? 3 : 1);
    chk(ctrl_a == exp_a, "R9", "final ctrl_a", 32'(ctrl_a), 32'(exp_a));
    chk(ctrl_b == exp_b, "R9", "final ctrl_b", 32'(ctrl_b), 32'(exp_b));
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule